// File: doc/BRIEF.md
# Dual-Lane Frame Stream Serializer

The block turns one frame of 16-bit words into serial bit streams on two output lanes, least significant bit first, together with a marker output that flags the first bit time of each frame. A frame carries two header words, a 32-bit frame counter split into two halves, two data-length words, the row data words, and two trailer words. The header and trailer values and the two lengths are configuration inputs. They are captured when a frame is accepted. Data words are pulled from an external word buffer through a per-port request and valid pair.

In dual-lane mode each lane sends its own stream, and each has its own data length. Lane 0 carries header 0, the low counter half, length 0, its data and trailer 0. Lane 1 carries header 1, the high counter half, length 1, its data and trailer 1. In single-lane mode the full sequence is sent on lane 0, and its data count is the sum of the two lengths. A rate select picks one clock per bit or two clocks per bit. A new word is loaded every 16 bit times. The internal 32-bit frame counter advances by one after each completed frame.

Top module: `fstream_tx`

## Requirements
- R1: After reset, `busy`, `lane0_out`, `lane1_out`, `frame_mark`, `buf0_req` and `buf1_req` are 0, and the first frame sent carries a frame counter value of 0.
- R2: With `dual_mode`=1, lane 0 sends header 0, counter bits 15:0, length 0, then `len0_words` data words, then trailer 0. Lane 1 sends header 1, counter bits 31:16, length 1, then `len1_words` data words, then trailer 1. A length word holds the length value in bits 10:0, and its upper bits are 0.
- R3: Every word occupies 16 consecutive bit periods, bit 0 first, with no gap between the words of a lane.
- R4: With `dual_mode`=0, lane 0 sends header 0, header 1, counter bits 15:0, counter bits 31:16, length 0, length 1, then `len0_words`+`len1_words` data words taken from buffer port 0, then trailer 0 and trailer 1. Lane 1 stays 0 for the whole frame.
- R5: A data length of zero skips the data phase, so the trailer word directly follows the last length word.
- R6: `frame_mark` is 1 during the first bit period of a frame and 0 at every other time.
- R7: With `full_rate`=1 a bit period is one clock. With `full_rate`=0 it is two clocks.
- R8: The frame counter sent in a frame equals the number of frames completed since reset, modulo 2^32.
- R9: Each data word causes exactly one single-cycle request on its buffer port (port 0 for lane 0, port 1 for lane 1). The word may be returned with its valid pulse in the same cycle as its request, or in any later cycle before the word's own slot starts.
- R10: A lane whose words run out sends 0 until the frame ends. The frame ends when the longer lane's last bit period is over. At that point `busy` falls and both lanes are 0.
- R11: `start_frame` is accepted only while `busy` is 0. The first bit appears after the second rising edge that counts the accepting edge, and a start held high through a frame starts the next frame right after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_frame | input | 1 | Request to send a frame; honoured only when idle |
| dual_mode | input | 1 | 1: two lanes with separate lengths; 0: everything on lane 0 |
| full_rate | input | 1 | 1: one clock per bit; 0: two clocks per bit |
| hdr0_word | input | 16 | First header word |
| hdr1_word | input | 16 | Second header word |
| trl0_word | input | 16 | First trailer word |
| trl1_word | input | 16 | Second trailer word |
| len0_words | input | 11 | Data word count for lane 0 |
| len1_words | input | 11 | Data word count for lane 1 |
| buf0_req | output | 1 | Word request on buffer port 0 |
| buf0_valid | input | 1 | Word returned on buffer port 0 |
| buf0_data | input | 16 | Returned word on port 0 |
| buf1_req | output | 1 | Word request on buffer port 1 |
| buf1_valid | input | 1 | Word returned on buffer port 1 |
| buf1_data | input | 16 | Returned word on port 1 |
| lane0_out | output | 1 | Serial lane 0 |
| lane1_out | output | 1 | Serial lane 1 |
| frame_mark | output | 1 | Frame start marker |
| busy | output | 1 | A frame is in progress |

## Verification
Two events can fall in the same cycle: the load edge that ends a frame and a new `start_frame`. The bench holds `start_frame` high through the whole of one frame. It then checks that the frame is not restarted while busy, that `busy` drops to 0 for exactly the cycle after the last bit, and that the next frame follows with the counter advanced by one. A second coincidence is a buffer word returning on the same edge that consumes the previous held word. Because the bench model answers each request in the request cycle, these two actions meet at the data-word load. Every reconstructed data word is then compared with its expected value.

// File: rtl/fstx_pkg.sv
// Package: shared framing constants and the frame state type.
// Assumes every word on a lane is of the same width.
package fstx_pkg;

    localparam int LANES       = 2;
    localparam int PRE_DUAL    = 3;   // header, counter half, length
    localparam int PRE_SINGLE  = 6;   // both headers, both halves, both lengths
    localparam int POST_DUAL   = 1;
    localparam int POST_SINGLE = 2;
    localparam int PRE_MAX     = PRE_SINGLE;
    localparam int POST_MAX    = POST_SINGLE;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } fstx_state_t;

endpackage

// File: rtl/fstx_timer.sv
// Bit timer: creates the bit-period tick and the word-load strobe.
// Assumes rate_full is held stable while run is high. The arm cycle
// loads the first word and restarts the bit count.
module fstx_timer #(
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic run,
    input  logic rate_full,
    output logic tick,
    output logic load,
    output logic bit_zero
);
    localparam int BIT_W = $clog2(WORD_W);

    logic             half_ph;
    logic [BIT_W-1:0] bitcnt;
    logic             last_bit;

    assign tick     = run && (rate_full || half_ph);
    assign last_bit = (bitcnt == BIT_W'(WORD_W - 1));
    assign load     = arm || (tick && last_bit);
    assign bit_zero = (bitcnt == '0);

    // Purpose: advance the half-rate phase and the bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_ph <= 1'b0;
            bitcnt  <= '0;
        end else if (arm) begin
            half_ph <= 1'b0;
            bitcnt  <= '0;
        end else if (run) begin
            half_ph <= ~half_ph;
            if (tick) begin
                bitcnt <= last_bit ? '0 : bitcnt + 1'b1;
            end
        end
    end

    // R3: bit position steps by one on each tick inside a word
    a_r3_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !last_bit && !arm) |=> (bitcnt == $past(bitcnt) + 1'b1));

    // R7: at half rate a tick is never followed by another tick
    a_r7_half_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !rate_full && tick) |=> !tick);

endmodule

// File: rtl/fstx_lane_seq.sv
// Lane word sequencer: on every load it chooses the next word of its
// lane. A lane has a prefix list, a data run from the buffer and a
// suffix list. One data word is prefetched into a holding register.
// Assumes the buffer answers each request before the slot of that word.
module fstx_lane_seq #(
    parameter int WORD_W   = 16,
    parameter int LEN_W    = 11,
    parameter int PRE_MAX  = 6,
    parameter int POST_MAX = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              restart,
    input  logic                              load,
    input  logic [PRE_MAX-1:0][WORD_W-1:0]    pre_words,
    input  logic [$clog2(PRE_MAX+1)-1:0]      pre_n,
    input  logic [POST_MAX-1:0][WORD_W-1:0]   post_words,
    input  logic [$clog2(POST_MAX+1)-1:0]     post_n,
    input  logic [LEN_W:0]                    dlen,
    input  logic                              buf_valid,
    input  logic [WORD_W-1:0]                 buf_data,
    output logic                              buf_req,
    output logic [WORD_W-1:0]                 word,
    output logic                              word_avail
);
    localparam int DLEN_W = LEN_W + 1;
    localparam int POS_W  = DLEN_W + 1;

    logic [POS_W-1:0]  pos, sel_pos, nxt_pos;
    logic [POS_W-1:0]  data_lo, data_hi, total, post_idx;
    logic              cur_is_data, nxt_is_data;
    logic [WORD_W-1:0] hold_data;
    logic              hold_full;

    assign sel_pos     = restart ? '0 : pos;
    assign nxt_pos     = sel_pos + 1'b1;
    assign data_lo     = POS_W'(pre_n);
    assign data_hi     = data_lo + POS_W'(dlen);
    assign total       = data_hi + POS_W'(post_n);
    assign post_idx    = sel_pos - data_hi;
    assign cur_is_data = (sel_pos >= data_lo) && (sel_pos < data_hi);
    assign nxt_is_data = (nxt_pos >= data_lo) && (nxt_pos < data_hi);
    assign word_avail  = (sel_pos < total);
    assign buf_req     = load && nxt_is_data;

    // Purpose: pick the word that belongs in the current slot.
    always_comb begin
        word = '0;
        if (sel_pos < data_lo) begin
            for (int i = 0; i < PRE_MAX; i++) begin
                if (sel_pos == POS_W'(i)) word = pre_words[i];
            end
        end else if (cur_is_data) begin
            word = hold_data;
        end else if (word_avail) begin
            for (int i = 0; i < POST_MAX; i++) begin
                if (post_idx == POS_W'(i)) word = post_words[i];
            end
        end
    end

    // Purpose: move the slot position forward on each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (load) begin
            pos <= nxt_pos;
        end
    end

    // Purpose: hold the prefetched buffer word until its slot uses it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else if (buf_valid) begin
            hold_data <= buf_data;
            hold_full <= 1'b1;
        end else if (restart || (load && cur_is_data)) begin
            hold_full <= 1'b0;
        end
    end

    // R9: a data slot never starts without its word in hand
    a_r9_word_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (load && cur_is_data) |-> hold_full);

    // R9: each request lasts a single cycle
    a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        buf_req |=> !buf_req);

endmodule

// File: rtl/fstx_shifter.sv
// Lane shifter: takes a word on load and shifts it out LSB first, one
// bit per tick. Drives 0 when its slot holds no word.
module fstx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              tick,
    input  logic [WORD_W-1:0] word,
    input  logic              word_avail,
    output logic              bit_out
);
    logic [WORD_W-1:0] sh;
    logic              act;

    assign bit_out = act & sh[0];

    // Purpose: load a new word or shift the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            act <= 1'b0;
        end else if (load) begin
            sh  <= word;
            act <= word_avail;
        end else if (tick) begin
            sh <= sh >> 1;
        end
    end

    // R3: the first bit after a load is bit 0 of the loaded word
    a_r3_lsb_first: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bit_out == ($past(word[0]) && $past(word_avail))));

endmodule

// File: rtl/fstream_tx.sv
// Frame stream serializer top. It accepts a frame start while idle,
// captures the configuration, assembles the per-lane word lists for
// the selected mode, and runs the two lane sequencers and shifters
// from one bit timer. The frame counter advances when both lanes are
// out of words. Assumes buffer words arrive in time (see R9).
module fstream_tx
    import fstx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_frame,
    input  logic              dual_mode,
    input  logic              full_rate,
    input  logic [WORD_W-1:0] hdr0_word,
    input  logic [WORD_W-1:0] hdr1_word,
    input  logic [WORD_W-1:0] trl0_word,
    input  logic [WORD_W-1:0] trl1_word,
    input  logic [LEN_W-1:0]  len0_words,
    input  logic [LEN_W-1:0]  len1_words,
    output logic              buf0_req,
    input  logic              buf0_valid,
    input  logic [WORD_W-1:0] buf0_data,
    output logic              buf1_req,
    input  logic              buf1_valid,
    input  logic [WORD_W-1:0] buf1_data,
    output logic              lane0_out,
    output logic              lane1_out,
    output logic              frame_mark,
    output logic              busy
);
    localparam int CNT_W  = 2 * WORD_W;
    localparam int DLEN_W = LEN_W + 1;
    localparam int PN_W   = $clog2(PRE_MAX + 1);
    localparam int QN_W   = $clog2(POST_MAX + 1);

    fstx_state_t       state;
    logic              dual_q, rate_q;
    logic [WORD_W-1:0] hdr0_q, hdr1_q, trl0_q, trl1_q;
    logic [LEN_W-1:0]  len0_q, len1_q;
    logic [CNT_W-1:0]  frame_cnt;
    logic              first_q;
    logic              arm, run, tick, load, bit_zero, frame_end;

    logic [LANES-1:0][PRE_MAX-1:0][WORD_W-1:0]  pre_w;
    logic [LANES-1:0][POST_MAX-1:0][WORD_W-1:0] post_w;
    logic [LANES-1:0][PN_W-1:0]                 pre_n;
    logic [LANES-1:0][QN_W-1:0]                 post_n;
    logic [LANES-1:0][DLEN_W-1:0]               dlen;
    logic [LANES-1:0][WORD_W-1:0]               bdata, lword;
    logic [LANES-1:0]                           bvalid, breq, avail, lbit;

    assign arm       = (state == ST_ARM);
    assign run       = (state == ST_RUN);
    assign busy      = (state != ST_IDLE);
    assign frame_end = run && load && (avail == '0);
    assign frame_mark = run && first_q && bit_zero;

    assign bvalid   = {buf1_valid, buf0_valid};
    assign bdata[0] = buf0_data;
    assign bdata[1] = buf1_data;
    assign buf0_req = breq[0];
    assign buf1_req = breq[1];
    assign lane0_out = lbit[0];
    assign lane1_out = lbit[1];

    // Purpose: step the frame state through idle, arm and run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start_frame) state <= ST_ARM;
                ST_ARM:  state <= ST_RUN;
                ST_RUN:  if (frame_end) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: capture the frame configuration when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dual_q <= 1'b0;
            rate_q <= 1'b0;
            hdr0_q <= '0;
            hdr1_q <= '0;
            trl0_q <= '0;
            trl1_q <= '0;
            len0_q <= '0;
            len1_q <= '0;
        end else if (state == ST_IDLE && start_frame) begin
            dual_q <= dual_mode;
            rate_q <= full_rate;
            hdr0_q <= hdr0_word;
            hdr1_q <= hdr1_word;
            trl0_q <= trl0_word;
            trl1_q <= trl1_word;
            len0_q <= len0_words;
            len1_q <= len1_words;
        end
    end

    // Purpose: count completed frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt <= '0;
        end else if (frame_end) begin
            frame_cnt <= frame_cnt + 1'b1;
        end
    end

    // Purpose: flag the first word of the frame for the marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
        end else if (arm) begin
            first_q <= 1'b1;
        end else if (load) begin
            first_q <= 1'b0;
        end
    end

    // Purpose: build each lane's prefix, data length and suffix for the mode.
    always_comb begin
        pre_w  = '0;
        post_w = '0;
        pre_n  = '0;
        post_n = '0;
        dlen   = '0;
        if (dual_q) begin
            pre_w[0][0]  = hdr0_q;
            pre_w[0][1]  = frame_cnt[WORD_W-1:0];
            pre_w[0][2]  = WORD_W'(len0_q);
            pre_n[0]     = PN_W'(PRE_DUAL);
            post_w[0][0] = trl0_q;
            post_n[0]    = QN_W'(POST_DUAL);
            dlen[0]      = DLEN_W'(len0_q);
            pre_w[1][0]  = hdr1_q;
            pre_w[1][1]  = frame_cnt[CNT_W-1:WORD_W];
            pre_w[1][2]  = WORD_W'(len1_q);
            pre_n[1]     = PN_W'(PRE_DUAL);
            post_w[1][0] = trl1_q;
            post_n[1]    = QN_W'(POST_DUAL);
            dlen[1]      = DLEN_W'(len1_q);
        end else begin
            pre_w[0][0]  = hdr0_q;
            pre_w[0][1]  = hdr1_q;
            pre_w[0][2]  = frame_cnt[WORD_W-1:0];
            pre_w[0][3]  = frame_cnt[CNT_W-1:WORD_W];
            pre_w[0][4]  = WORD_W'(len0_q);
            pre_w[0][5]  = WORD_W'(len1_q);
            pre_n[0]     = PN_W'(PRE_SINGLE);
            post_w[0][0] = trl0_q;
            post_w[0][1] = trl1_q;
            post_n[0]    = QN_W'(POST_SINGLE);
            dlen[0]      = DLEN_W'(len0_q) + DLEN_W'(len1_q);
        end
    end

    fstx_timer #(.WORD_W(WORD_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .run       (run),
        .rate_full (rate_q),
        .tick      (tick),
        .load      (load),
        .bit_zero  (bit_zero)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fstx_lane_seq #(
            .WORD_W   (WORD_W),
            .LEN_W    (LEN_W),
            .PRE_MAX  (PRE_MAX),
            .POST_MAX (POST_MAX)
        ) u_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .restart    (arm),
            .load       (load),
            .pre_words  (pre_w[g]),
            .pre_n      (pre_n[g]),
            .post_words (post_w[g]),
            .post_n     (post_n[g]),
            .dlen       (dlen[g]),
            .buf_valid  (bvalid[g]),
            .buf_data   (bdata[g]),
            .buf_req    (breq[g]),
            .word       (lword[g]),
            .word_avail (avail[g])
        );

        fstx_shifter #(.WORD_W(WORD_W)) u_shift (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .tick       (tick),
            .word       (lword[g]),
            .word_avail (avail[g]),
            .bit_out    (lbit[g])
        );
    end

    // R1: lanes and marker stay quiet while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!lane0_out && !lane1_out && !frame_mark));

    // R11: a frame only begins after a sampled start
    a_r11_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_frame));

    // R8: the counter moves only as a frame finishes
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_cnt) |-> ($fell(busy) && frame_cnt == $past(frame_cnt) + 1'b1));

    // R6: the marker rises right after the arm cycle
    a_r6_marker_align: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_mark) |-> $past(arm));

endmodule

// File: tb/fstream_tx_tb.sv
module fstream_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXW       = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_frame = 1'b0;
    logic        dual_mode = 1'b1;
    logic        full_rate = 1'b1;
    logic [15:0] hdr0_word = '0, hdr1_word = '0, trl0_word = '0, trl1_word = '0;
    logic [10:0] len0_words = '0, len1_words = '0;
    logic        buf0_req, buf1_req;
    logic        buf0_valid = 1'b0, buf1_valid = 1'b0;
    logic [15:0] buf0_data = '0, buf1_data = '0;
    logic        lane0_out, lane1_out, frame_mark, busy;

    int checks = 0;
    int failures = 0;
    int idx0 = 0, idx1 = 0;
    int n0, n1, r0, r1;
    logic [31:0] exp_cnt = '0;
    logic [15:0] e0 [MAXW];
    logic [15:0] e1 [MAXW];
    logic [15:0] g0 [MAXW];
    logic [15:0] g1 [MAXW];

    always #(CLK_PERIOD/2) clk = ~clk;

    fstream_tx u_dut (
        .clk(clk), .rst_n(rst_n), .start_frame(start_frame),
        .dual_mode(dual_mode), .full_rate(full_rate),
        .hdr0_word(hdr0_word), .hdr1_word(hdr1_word),
        .trl0_word(trl0_word), .trl1_word(trl1_word),
        .len0_words(len0_words), .len1_words(len1_words),
        .buf0_req(buf0_req), .buf0_valid(buf0_valid), .buf0_data(buf0_data),
        .buf1_req(buf1_req), .buf1_valid(buf1_valid), .buf1_data(buf1_data),
        .lane0_out(lane0_out), .lane1_out(lane1_out),
        .frame_mark(frame_mark), .busy(busy)
    );

    function automatic logic [15:0] pat(input int ln, input int i);
        return 16'((i * 263) ^ (i << 9) ^ ((ln != 0) ? 32'hA5C3 : 32'h5A3C));
    endfunction

    // buffer model: answers each request in the request cycle
    initial begin
        forever begin
            @(negedge clk);
            buf0_valid = buf0_req;
            buf1_valid = buf1_req;
            if (buf0_req) begin buf0_data = pat(0, idx0); idx0++; end
            if (buf1_req) begin buf1_data = pat(1, idx1); idx1++; end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic build_exp(input bit dual, input int l0, input int l1);
        for (int i = 0; i < MAXW; i++) begin e0[i] = '0; e1[i] = '0; end
        if (dual) begin
            e0[0] = hdr0_word; e0[1] = exp_cnt[15:0];  e0[2] = 16'(l0);
            for (int i = 0; i < l0; i++) e0[3+i] = pat(0, i);
            e0[3+l0] = trl0_word; n0 = 4 + l0; r0 = l0;
            e1[0] = hdr1_word; e1[1] = exp_cnt[31:16]; e1[2] = 16'(l1);
            for (int i = 0; i < l1; i++) e1[3+i] = pat(1, i);
            e1[3+l1] = trl1_word; n1 = 4 + l1; r1 = l1;
        end else begin
            e0[0] = hdr0_word; e0[1] = hdr1_word;
            e0[2] = exp_cnt[15:0]; e0[3] = exp_cnt[31:16];
            e0[4] = 16'(l0); e0[5] = 16'(l1);
            for (int i = 0; i < l0 + l1; i++) e0[6+i] = pat(0, i);
            e0[6+l0+l1] = trl0_word; e0[7+l0+l1] = trl1_word;
            n0 = 8 + l0 + l1; r0 = l0 + l1; n1 = 0; r1 = 0;
        end
    endtask

    // runs one frame from a negedge and ends at a negedge
    task automatic run_frame(input bit dual, input bit full, input int l0, input int l1,
                             input bit keep_start, input string tag);
        int p, nw, total, mk_bad, bad0, bad1, cidx;
        p = full ? 1 : 2;
        dual_mode = dual; full_rate = full;
        len0_words = 11'(l0); len1_words = 11'(l1);
        hdr0_word = 16'hF0E1 ^ 16'(l0 * 17); hdr1_word = 16'h1D2C ^ 16'(l1 * 5);
        trl0_word = 16'hB00C ^ 16'(l1); trl1_word = 16'h7E81 ^ 16'(l0);
        build_exp(dual, l0, l1);
        for (int i = 0; i < MAXW; i++) begin g0[i] = '0; g1[i] = '0; end
        idx0 = 0; idx1 = 0;
        start_frame = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (!keep_start) start_frame = 1'b0;
        check(busy == 1'b1, "R11", {tag, " busy after start"}, busy, 1);
        @(posedge clk);
        @(negedge clk);
        nw = (n0 > n1) ? n0 : n1;
        total = nw * 16 * p;
        mk_bad = 0;
        for (int c = 0; c < total; c++) begin
            int b;
            b = c / p;
            g0[b / 16][b % 16] = lane0_out;
            g1[b / 16][b % 16] = lane1_out;
            if (frame_mark !== (c < p)) mk_bad++;
            @(negedge clk);
        end
        check(busy == 1'b0 && lane0_out == 1'b0 && lane1_out == 1'b0, "R10",
              {tag, " idle after last bit"}, {busy, lane0_out, lane1_out}, 0);
        check(g0[0] == e0[0], "R3", {tag, " first word LSB first"}, g0[0], e0[0]);
        cidx = dual ? 1 : 2;
        check(g0[cidx] == exp_cnt[15:0], "R8", {tag, " counter low half"}, g0[cidx], exp_cnt[15:0]);
        bad0 = -1; bad1 = -1;
        for (int i = nw - 1; i >= 0; i--) begin
            if (g0[i] != e0[i]) bad0 = i;
            if (g1[i] != e1[i]) bad1 = i;
        end
        if (bad0 < 0) check(1'b1, tag, "lane0", 0, 0);
        else check(1'b0, tag, $sformatf("lane0 word %0d", bad0), g0[bad0], e0[bad0]);
        if (bad1 < 0) check(1'b1, "R10", "lane1", 0, 0);
        else check(1'b0, (dual ? tag : "R4"), $sformatf("lane1 word %0d", bad1), g1[bad1], e1[bad1]);
        check(mk_bad == 0, "R6", {tag, " marker cycles wrong"}, mk_bad, 0);
        check(idx0 == r0 && idx1 == r1, "R9", {tag, " request counts"},
              (idx0 << 16) | idx1, (r0 << 16) | r1);
        exp_cnt++;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && lane0_out == 0 && lane1_out == 0 && frame_mark == 0 &&
              buf0_req == 0 && buf1_req == 0, "R1", "outputs after reset",
              {busy, lane0_out, lane1_out, frame_mark, buf0_req, buf1_req}, 0);
    endtask

    task automatic test_dual_basic();    run_frame(1, 1, 3, 5, 0, "R2"); endtask
    task automatic test_half_rate();     run_frame(1, 0, 4, 2, 0, "R7"); endtask
    task automatic test_single();        run_frame(0, 1, 2, 3, 0, "R4"); endtask
    task automatic test_zero_len();
        run_frame(1, 1, 0, 2, 0, "R5");
        run_frame(0, 0, 0, 0, 0, "R5");
    endtask
    task automatic test_back_to_back();
        run_frame(1, 1, 1, 1, 1, "R11");
        run_frame(0, 1, 1, 0, 0, "R11");
    endtask
    task automatic test_max_len();       run_frame(1, 1, 1850, 3, 0, "R2"); endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        test_reset();
        test_dual_basic();
        test_half_rate();
        test_single();
        test_zero_len();
        test_back_to_back();
        test_max_len();
        repeat (4) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule